// File: doc/BRIEF.md
# Sampled Phase-Frequency Comparator with Lock Indicator

This block compares two streams of single-cycle pulses in a fast sampling clock domain. One stream is the divided reference and the other is the divided oscillator feedback. Each pulse sets a pending flag for its own side. When both flags are set, they overlap for a fixed number of clocks and are then cleared together. The flag that was set first stays high for the time between the two pulses plus that fixed overlap. The trailing flag stays high for the overlap alone. So even a perfectly aligned pair drives both pump controls briefly, which keeps the pump out of a dead zone. A second pulse on the same side before the other side answers is absorbed into the pending flag. This lets the comparator resolve errors beyond one period as a frequency error.

A run-time polarity input decides which internal flag drives the raise control and which drives the lower control. This suits oscillators whose frequency falls as the control voltage rises. A drive-enable output is high whenever either control is active. When it is low, the pump stage must float its output.

The lock indicator counts the clocks during which exactly one flag is pending. A count that reaches the unlock threshold clears the indicator at once. The indicator sets again only after a run of consecutive comparisons whose error is below a smaller lock threshold. An error between the two thresholds leaves the indicator as it is, but it restarts the run.

Top module: `phase_cmp_lock`

## Requirements
- R1: While reset is asserted, and on the first clock after it, pumpUp, pumpDn, pumpDrive and lockOut are all low.
- R2: When refPulse and vcoPulse arrive in the same cycle, pumpUp and pumpDn each go high for exactly MIN_W (default 2) cycles, starting the cycle after the pulses.
- R3: With polSel = 0, if refPulse leads vcoPulse by d cycles, pumpUp is high for d + MIN_W cycles and pumpDn for MIN_W cycles. Both fall together.
- R4: With polSel = 0, if vcoPulse leads refPulse by d cycles, pumpDn is high for d + MIN_W cycles and pumpUp for MIN_W cycles.
- R5: With polSel = 1, the roles in R3 and R4 are exchanged: the flag set by refPulse drives pumpDn, and the flag set by vcoPulse drives pumpUp.
- R6: pumpDrive is high in exactly the cycles where pumpUp or pumpDn is high. When it is low, the pump output is meant to be high-impedance.
- R7: A further refPulse while the reference flag is already pending, with no vcoPulse in between, keeps that flag high and the opposite control low until a vcoPulse arrives.
- R8: A phase error is the number of cycles during which exactly one flag is pending. When it reaches UNLOCK_TH (default 4) or more, lockOut goes low.
- R9: lockOut goes high only after LOCK_COUNT (default 3) consecutive completed comparisons, each with an error below LOCK_TH (default 2).
- R10: A comparison whose error is at least LOCK_TH but below UNLOCK_TH leaves lockOut unchanged and restarts the count of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | Single-cycle pulse from the reference divider |
| vcoPulse | input | 1 | Single-cycle pulse from the feedback divider |
| polSel | input | 1 | 0: reference flag drives pumpUp; 1: roles swapped |
| pumpUp | output | 1 | Raise the control voltage |
| pumpDn | output | 1 | Lower the control voltage |
| pumpDrive | output | 1 | Pump output enable; low means high-impedance |
| lockOut | output | 1 | Lock indicator |

## Verification
The bench measures the high time of each control and of the enable, comparing the measured time against the lead or lag of every comparison. It does this under both polarity settings, so a design with swapped roles or a wrong overlap length shows up as a width mismatch. A design that ignored a repeated reference pulse, or that reset its flag on it, would drop the raise control early or raise the lower control, and the frequency-error case catches this. The lock-indicator cases place errors just below LOCK_TH, inside the hysteresis band and at UNLOCK_TH. They also interrupt a good run partway, so a detector without hysteresis, with an off-by-one run length, or one that failed to restart its run would report lock in the wrong comparison.

// File: rtl/phase_cmp_pkg.sv
package phase_cmp_pkg;
  // Strobes from the flag control to the measuring datapath
  typedef struct packed {
    logic errStep;   // exactly one flag pending this cycle
    logic measDone;  // comparison completes, flags clear at this edge
  } cmpStrobe_t;
endpackage

// File: rtl/phase_cmp_ctrl.sv
module phase_cmp_ctrl
  import phase_cmp_pkg::*;
#(
  parameter int MIN_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refPulse,
  input  logic       vcoPulse,
  output logic       refFlag,
  output logic       vcoFlag,
  output cmpStrobe_t strobe
);
  localparam int OV_W = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [OV_W-1:0] OV_LAST = OV_W'(MIN_W - 1);

  logic [OV_W-1:0] ovCnt;
  logic bothHigh;
  logic clrNow;

  assign bothHigh = refFlag & vcoFlag;
  assign clrNow   = bothHigh && (ovCnt == OV_LAST);

  // A new pulse wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refFlag <= 1'b0;
      vcoFlag <= 1'b0;
      ovCnt   <= '0;
    end else begin
      refFlag <= (refFlag & ~clrNow) | refPulse;
      vcoFlag <= (vcoFlag & ~clrNow) | vcoPulse;
      if (!bothHigh || clrNow) ovCnt <= '0;
      else                     ovCnt <= ovCnt + 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.errStep  = refFlag ^ vcoFlag;
    strobe.measDone = clrNow;
  end
endmodule

// File: rtl/phase_cmp_dpath.sv
module phase_cmp_dpath
  import phase_cmp_pkg::*;
#(
  parameter int UNLOCK_TH  = 4,
  parameter int LOCK_TH    = 2,
  parameter int LOCK_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refFlag,
  input  logic       vcoFlag,
  input  logic       polSel,
  input  cmpStrobe_t strobe,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpDrive,
  output logic       lockOut
);
  localparam int ERR_W  = $clog2(UNLOCK_TH + 1);
  localparam int GOOD_W = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1;
  localparam logic [ERR_W-1:0]  ERR_MAX   = ERR_W'(UNLOCK_TH);
  localparam logic [ERR_W-1:0]  ERR_GOOD  = ERR_W'(LOCK_TH);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  logic [ERR_W-1:0]  errCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic              lockQ;
  logic              tooBig;

  assign tooBig = (errCnt >= ERR_MAX);

  // Saturating one-sided-pending counter, cleared per comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                errCnt <= '0;
    else if (strobe.measDone)                  errCnt <= '0;
    else if (strobe.errStep && errCnt != ERR_MAX) errCnt <= errCnt + 1'b1;
  end

  // Lock indicator with hysteresis
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockQ   <= 1'b0;
      goodCnt <= '0;
    end else if (tooBig) begin
      lockQ   <= 1'b0;
      goodCnt <= '0;
    end else if (strobe.measDone) begin
      if (errCnt < ERR_GOOD) begin
        if (goodCnt >= GOOD_LAST) lockQ   <= 1'b1;
        else                      goodCnt <= goodCnt + 1'b1;
      end else begin
        goodCnt <= '0;
      end
    end
  end

  // Polarity steering
  always_comb begin
    if (polSel) begin
      pumpUp = vcoFlag;
      pumpDn = refFlag;
    end else begin
      pumpUp = refFlag;
      pumpDn = vcoFlag;
    end
  end

  assign pumpDrive = refFlag | vcoFlag;
  assign lockOut   = lockQ;
endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock
  import phase_cmp_pkg::*;
#(
  parameter int MIN_W      = 2,
  parameter int UNLOCK_TH  = 4,
  parameter int LOCK_TH    = 2,
  parameter int LOCK_COUNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refPulse,
  input  logic vcoPulse,
  input  logic polSel,
  output logic pumpUp,
  output logic pumpDn,
  output logic pumpDrive,
  output logic lockOut
);
  logic       refFlag;
  logic       vcoFlag;
  cmpStrobe_t strobe;

  phase_cmp_ctrl #(.MIN_W(MIN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .refPulse(refPulse), .vcoPulse(vcoPulse),
    .refFlag(refFlag), .vcoFlag(vcoFlag), .strobe(strobe)
  );

  phase_cmp_dpath #(
    .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH), .LOCK_COUNT(LOCK_COUNT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .refFlag(refFlag), .vcoFlag(vcoFlag),
    .polSel(polSel), .strobe(strobe), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpDrive(pumpDrive), .lockOut(lockOut)
  );
endmodule

// File: rtl/phase_cmp_chk.sv
module phase_cmp_chk #(
  parameter int MIN_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic refPulse,
  input logic vcoPulse,
  input logic polSel,
  input logic pumpUp,
  input logic pumpDn,
  input logic pumpDrive,
  input logic lockOut
);
  localparam int RUN_W = $clog2(MIN_W + 1);
  logic [RUN_W-1:0] runCnt;
  logic both;
  assign both = pumpUp & pumpDn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 runCnt <= '0;
    else if (both && runCnt != RUN_W'(MIN_W - 1)) runCnt <= runCnt + 1'b1;
    else                                        runCnt <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!pumpUp && !pumpDn && !pumpDrive && !lockOut));

  // R3
  ref_sets_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refPulse |=> (polSel ? pumpDn : pumpUp));

  // R4
  vco_sets_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcoPulse |=> (polSel ? pumpUp : pumpDn));

  // R2
  overlap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && runCnt == RUN_W'(MIN_W - 1) && !refPulse && !vcoPulse)
      |=> (!pumpUp && !pumpDn));

  // R6
  drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pumpDrive) |-> (!pumpUp && !pumpDn));

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockOut) |-> $past(both));
endmodule

bind phase_cmp_lock phase_cmp_chk #(.MIN_W(MIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refPulse(refPulse), .vcoPulse(vcoPulse),
  .polSel(polSel), .pumpUp(pumpUp), .pumpDn(pumpDn),
  .pumpDrive(pumpDrive), .lockOut(lockOut)
);

// File: tb/sim_phase_cmp_lock.sv
module sim_phase_cmp_lock;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_W = 2;
  localparam int UNLOCK_TH = 4;
  localparam int LOCK_TH = 2;
  localparam int LOCK_COUNT = 3;
  localparam int SLOT = 20;
  localparam int BASE = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refPulse = 1'b0;
  logic vcoPulse = 1'b0;
  logic polSel = 1'b0;
  logic pumpUp, pumpDn, pumpDrive, lockOut;

  int checks = 0;
  int errors = 0;
  bit lockExp = 1'b0;
  int goodExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_cmp_lock #(.MIN_W(MIN_W), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH),
                   .LOCK_COUNT(LOCK_COUNT)) u0 (
    .clk(clk), .rst_n(rst_n), .refPulse(refPulse), .vcoPulse(vcoPulse),
    .polSel(polSel), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpDrive(pumpDrive), .lockOut(lockOut)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Reference model of the lock indicator for one completed comparison
  task automatic modelLock(int err);
    if (err >= UNLOCK_TH) begin
      lockExp = 1'b0; goodExp = 0;
    end else if (err < LOCK_TH) begin
      goodExp = (goodExp + 1 > LOCK_COUNT) ? LOCK_COUNT : goodExp + 1;
      if (goodExp >= LOCK_COUNT) lockExp = 1'b1;
    end else begin
      goodExp = 0;
    end
  endtask

  function automatic string lockTag(int err);
    if (err >= UNLOCK_TH) return "R8";
    if (err >= LOCK_TH) return "R10";
    return "R9";
  endfunction

  // One comparison: ref at BASE, vco at BASE+d
  task automatic runSlot(int d, bit pol);
    int upW = 0, dnW = 0, drW = 0, lk = 0;
    int longW, refW, vcoW;
    string tag;
    for (int c = 0; c < SLOT; c++) begin
      @(negedge clk);
      upW += int'(pumpUp); dnW += int'(pumpDn); drW += int'(pumpDrive);
      if (c == SLOT - 1) lk = int'(lockOut);
      if (c == 0) polSel = pol;
      refPulse = (c == BASE);
      vcoPulse = (c == BASE + d);
    end
    longW = absv(d) + MIN_W;
    refW  = (d > 0) ? longW : MIN_W;
    vcoW  = (d < 0) ? longW : MIN_W;
    if (pol)        tag = "R5";
    else if (d == 0) tag = "R2";
    else if (d > 0)  tag = "R3";
    else             tag = "R4";
    chk({tag, " up width"}, upW, pol ? vcoW : refW);
    chk({tag, " dn width"}, dnW, pol ? refW : vcoW);
    chk("R6 drive width", drW, longW);
    modelLock(absv(d));
    chk({lockTag(absv(d)), " lockOut"}, lk, int'(lockExp));
  endtask

  // Two reference pulses before one feedback pulse
  task automatic runFreqErr(bit pol);
    int upW = 0, dnW = 0, drW = 0, midUp = 0, midDn = 0, lk = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      upW += int'(pumpUp); dnW += int'(pumpDn); drW += int'(pumpDrive);
      if (c == 16) begin midUp = int'(pumpUp); midDn = int'(pumpDn); end
      if (c == 31) lk = int'(lockOut);
      if (c == 0) polSel = pol;
      refPulse = (c == 2) || (c == 12);
      vcoPulse = (c == 22);
    end
    chk("R7 ref side held", pol ? midDn : midUp, 1);
    chk("R7 other side low", pol ? midUp : midDn, 0);
    chk("R7 ref side width", pol ? dnW : upW, 20 + MIN_W);
    chk("R7 other side width", pol ? upW : dnW, MIN_W);
    chk("R6 drive width freq", drW, 20 + MIN_W);
    modelLock(UNLOCK_TH);
    chk("R8 lockOut after freq err", lk, int'(lockExp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    chk("R1 pumpUp reset", int'(pumpUp), 0);
    chk("R1 pumpDn reset", int'(pumpDn), 0);
    chk("R1 pumpDrive reset", int'(pumpDrive), 0);
    chk("R1 lockOut reset", int'(lockOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lockOut after release", int'(lockOut), 0);
    chk("R1 pumpDrive after release", int'(pumpDrive), 0);

    // Lock entry, hysteresis band, exit
    runSlot(0, 1'b0);
    runSlot(1, 1'b0);
    runSlot(-1, 1'b1);   // R9 third good comparison locks
    runSlot(3, 1'b0);    // R10 band keeps lock
    runSlot(-3, 1'b1);
    runSlot(4, 1'b0);    // R8 exactly at threshold unlocks
    runSlot(0, 1'b0);
    runSlot(0, 1'b0);
    runSlot(2, 1'b0);    // R10 restart of run while unlocked
    runSlot(0, 1'b1);
    runSlot(0, 1'b0);
    runSlot(-1, 1'b0);   // R9 locks again
    runFreqErr(1'b0);
    runSlot(0, 1'b0); runSlot(0, 1'b0); runSlot(0, 1'b0);
    runFreqErr(1'b1);

    for (int i = 0; i < 150; i++) begin
      int d;
      int unsigned r;
      r = $urandom;
      if (r[3:0] < 4'd6) d = int'(r[5:4]) % 2;
      else d = int'($urandom_range(12, 0)) - 6;
      runSlot(d, r[8]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule